// File: doc/BRIEF.md
# Aperture Address Translator

This block sits on the inbound path of a bus and remaps addresses that land inside a configurable aperture window onto 40-bit physical addresses. The window comes from two control inputs. A 3-bit order selects a size of 32 MB times a power of two. A 15-bit base field, shifted up by 25 bits, places the window. An enable bit switches translation on or off. Addresses outside the window, or any address while the window is off, come back unchanged with zero extension.

Each 4 KB page of the window has one 32-bit entry in an internal table RAM. Software loads the table through a write port. An entry carries the physical frame bits 31:12 in place. It carries the physical bits 39:32 in entry bits 11:4, a valid flag in bit 0 and a coherent flag in bit 1. The block keeps a four-entry, fully associative cache of recently used frames. A table write leaves the cache untouched, so software must pulse the flush input once it has changed the table.

Requests and responses each use a valid/ready handshake, and one request is in flight at a time. A cache hit or a pass-through responds one cycle after acceptance. A table lookup responds two cycles after acceptance.

Top module: `gart_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and req_ready is 1.
- R2: An address outside the window is returned as {8'h00, req_addr} with rsp_fault=0 and rsp_xlat=0, one cycle after acceptance.
- R3: The window is [B, B+S), where B = cfg_base << 25 and S = 32 MB << cfg_ctl[3:1]. Both ends of the window are honoured exactly.
- R4: If B+S exceeds 2^32, the window is disabled and every address passes through. B+S equal to 2^32 is still enabled.
- R5: When cfg_ctl[0] is 0, translation is off and every address passes through.
- R6: Inside the window, the page index is (req_addr − B) >> 12. The result is {E[11:4], E[31:12], req_addr[11:0]}, where E is the table entry at that index and E[0]=1. rsp_xlat is 1.
- R7: A window hit on an entry with E[0]=0 returns rsp_fault=1 and rsp_addr=0.
- R8: A window hit whose page index is at or beyond the table depth returns rsp_fault=1 and rsp_addr=0 without a table read.
- R9: A cache hit responds 1 cycle after acceptance. A cache miss responds 2 cycles after acceptance.
- R10: A table write does not change a cached translation. After flush, every page is looked up in the table again.
- R11: The cache holds 4 pages and replaces them round-robin, starting at slot 0 after reset or flush. Only valid entries are cached.
- R12: While rsp_valid=1 and rsp_ready=0, the response stays stable and req_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctl | input | 4 | Bit 0 enables translation; bits 3:1 hold the size order |
| cfg_base | input | 15 | Window base in 32 MB units |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | TBL_AW | Table entry index |
| tbl_wdata | input | 32 | Table entry value |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Bus address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_addr | output | 40 | Physical or passed-through address |
| rsp_fault | output | 1 | Invalid entry or index out of table |
| rsp_xlat | output | 1 | Address fell inside the window |

## Verification
The embedded properties check, on every cycle, that a stalled response holds steady and blocks new requests. They also check that faults carry a zero address, that pass-through results never fault or set upper bits, that a table read always produces a response on the next cycle, and that the cache never matches two slots at once. Other behaviours can only be shown through directed scenarios. These include the window arithmetic at its edges and at the 4 GB limit, the entry bit-packing, and the one-versus-two-cycle latency. They also include stale hits after table writes, the refetch after a flush, and which page the round-robin pointer evicts.

// File: rtl/gart_pkg.sv
package gart_pkg;
  localparam int PG_SHIFT = 12;
  localparam int VA_W     = 32;
  localparam int PA_W     = 40;
  localparam int PG_W     = VA_W - PG_SHIFT;
  localparam int FR_W     = PA_W - PG_SHIFT;

  typedef enum logic {S_IDLE, S_FILL} xlat_state_e;

  // frame number carried by an entry: high byte at 11:4, low frame at 31:12
  function automatic logic [FR_W-1:0] entry_frame(input logic [31:0] e);
    return {e[11:4], e[31:12]};
  endfunction
endpackage

// File: rtl/gart_aperture.sv
module gart_aperture
  import gart_pkg::*;
(
  input  logic [3:0]      cfg_ctl,
  input  logic [14:0]     cfg_base,
  input  logic [VA_W-1:0] addr,
  output logic            win_hit,
  output logic [PG_W-1:0] page
);
  localparam logic [40:0] LIMIT_4G = 41'h1_0000_0000;
  localparam logic [40:0] UNIT_32M = 41'h0_0200_0000;

  logic [40:0] base_ext, size_ext, top_ext, addr_ext;
  logic        live;

  always_comb begin
    base_ext = 41'(cfg_base) << 25;
    size_ext = UNIT_32M << cfg_ctl[3:1];
    top_ext  = base_ext + size_ext;
    addr_ext = 41'(addr);
    live     = cfg_ctl[0] && (top_ext <= LIMIT_4G) && (size_ext != 41'd0);
    win_hit  = live && (addr_ext >= base_ext) && (addr_ext < top_ext);
    page     = addr[VA_W-1:PG_SHIFT] - base_ext[VA_W-1:PG_SHIFT];
  end
endmodule

// File: rtl/gart_table.sv
module gart_table #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gart_tlb.sv
module gart_tlb #(
  parameter int N  = 4,
  parameter int TW = 20,
  parameter int DW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [TW-1:0] lk_tag,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  input  logic          fill_en,
  input  logic [TW-1:0] fill_tag,
  input  logic [DW-1:0] fill_data
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  vld;
  logic [TW-1:0] tag [N];
  logic [DW-1:0] dat [N];
  logic [N-1:0]  hit_vec;
  logic [PW-1:0] ptr;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tag[g] == lk_tag);
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) lk_data = lk_data | dat[i];
    lk_hit = |hit_vec;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag[ptr] <= fill_tag;
      dat[ptr] <= fill_data;
    end
  end

  // R11: a page is never cached in two slots
  p_single_match_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R10: nothing survives a flush
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
  import gart_pkg::*;
#(
  parameter int TBL_AW = 10,
  parameter int TLB_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cfg_ctl,
  input  logic [14:0]       cfg_base,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_waddr,
  input  logic [31:0]       tbl_wdata,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_addr,
  output logic              rsp_fault,
  output logic              rsp_xlat
);
  xlat_state_e           state;
  logic                  win_hit, in_tbl, accept, tlb_hit, fill_en;
  logic [PG_W-1:0]       page, pend_tag;
  logic [PG_SHIFT-1:0]   pend_off;
  logic [FR_W-1:0]       tlb_frame;
  logic [31:0]           ram_q;
  logic [2:0]            unused_flags;

  gart_aperture u_ap (
    .cfg_ctl (cfg_ctl), .cfg_base(cfg_base), .addr(req_addr),
    .win_hit (win_hit), .page(page)
  );

  gart_table #(.AW(TBL_AW), .DW(32)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(page[TBL_AW-1:0]), .rdata(ram_q)
  );

  gart_tlb #(.N(TLB_N), .TW(PG_W), .DW(FR_W)) u_tlb (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_tag(page), .lk_hit(tlb_hit), .lk_data(tlb_frame),
    .fill_en(fill_en), .fill_tag(pend_tag), .fill_data(entry_frame(ram_q))
  );

  assign unused_flags = ram_q[3:1];
  assign in_tbl    = (page[PG_W-1:TBL_AW] == '0);
  assign req_ready = (state == S_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign fill_en   = (state == S_FILL) && ram_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
      rsp_xlat  <= 1'b0;
      pend_tag  <= '0;
      pend_off  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          pend_tag <= page;
          pend_off <= req_addr[PG_SHIFT-1:0];
          if (!win_hit) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= PA_W'(req_addr);
            rsp_fault <= 1'b0;
            rsp_xlat  <= 1'b0;
          end else if (!in_tbl) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= '0;
            rsp_fault <= 1'b1;
            rsp_xlat  <= 1'b1;
          end else if (tlb_hit) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= {tlb_frame, req_addr[PG_SHIFT-1:0]};
            rsp_fault <= 1'b0;
            rsp_xlat  <= 1'b1;
          end else begin
            state <= S_FILL;
          end
        end
        S_FILL: begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_xlat  <= 1'b1;
          rsp_fault <= !ram_q[0];
          rsp_addr  <= ram_q[0] ? {entry_frame(ram_q), pend_off} : '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: stalled response holds
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault) && $stable(rsp_xlat));
  // R12: no new request while a response is pending
  p_busy_block_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
  // R7 / R8: faults carry a zero address and only occur inside the window
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_addr == '0 && rsp_xlat);
  // R2: pass-through never faults and never sets bits above 31
  p_pass_clean_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_xlat |-> !rsp_fault && rsp_addr[PA_W-1:VA_W] == '0);
  // R9: a table read is answered on the following cycle
  p_fill_latency_r9: assert property (@(posedge clk) disable iff (rst)
    state == S_FILL |=> rsp_valid && rsp_xlat);
endmodule

// File: tb/gart_xlate_test.sv
module gart_xlate_test;
  localparam int TBL_AW = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        cfg_ctl = 4'b0001;
  logic [14:0]       cfg_base = 15'd4;
  logic              tbl_we = 1'b0;
  logic [TBL_AW-1:0] tbl_waddr = '0;
  logic [31:0]       tbl_wdata = '0;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [31:0]       req_addr = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [39:0]       rsp_addr;
  logic              rsp_fault;
  logic              rsp_xlat;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gart_xlate #(.TBL_AW(TBL_AW), .TLB_N(4)) uut (
    .clk(clk), .rst(rst), .cfg_ctl(cfg_ctl), .cfg_base(cfg_base),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_xlat(rsp_xlat)
  );

  function automatic logic [31:0] mk_ent(input logic [39:0] pa, input logic v);
    return {pa[31:12], pa[39:32], 2'b00, 2'b10 | {1'b0, v}};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbl_write(input int idx, input logic [31:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = TBL_AW'(idx); tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic run_req(input logic [31:0] a, output logic [39:0] pa,
                         output logic f, output logic x, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 10) begin
      @(negedge clk); lat++;
    end
    pa = rsp_addr; f = rsp_fault; x = rsp_xlat;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_xlat(input string req, input logic [31:0] a,
                             input logic [39:0] epa, input logic ef, input logic ex, input int elat);
    logic [39:0] pa; logic f, x; int lat;
    run_req(a, pa, f, x, lat);
    check({req, " addr"}, 64'(pa), 64'(epa));
    check({req, " fault"}, 64'(f), 64'(ef));
    check({req, " xlat"}, 64'(x), 64'(ex));
    if (elat > 0) check({req, " latency"}, 64'(lat), 64'(elat));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_pass();
    expect_xlat("R2 below base", 32'h07FF_FFFF, 40'h00_07FF_FFFF, 1'b0, 1'b0, 1);
    expect_xlat("R3 window top end", 32'h0A00_0000, 40'h00_0A00_0000, 1'b0, 1'b0, 1);
    expect_xlat("R2 far address", 32'hC234_5678, 40'h00_C234_5678, 1'b0, 1'b0, 1);
  endtask

  task automatic t_translate();
    tbl_write(0, mk_ent(40'h9A_1234_5000, 1'b1));
    tbl_write(5, mk_ent(40'h01_FEDC_B000, 1'b1));
    do_flush();
    expect_xlat("R6 page0 miss", 32'h0800_0ABC, 40'h9A_1234_5ABC, 1'b0, 1'b1, 2);
    expect_xlat("R9 page0 hit", 32'h0800_0ABC, 40'h9A_1234_5ABC, 1'b0, 1'b1, 1);
    expect_xlat("R6 page5", 32'h0800_5123, 40'h01_FEDC_B123, 1'b0, 1'b1, 2);
  endtask

  task automatic t_invalid();
    tbl_write(7, mk_ent(40'h55_1234_5000, 1'b0));
    expect_xlat("R7 invalid entry", 32'h0800_7040, 40'h0, 1'b1, 1'b1, 2);
    expect_xlat("R11 invalid not cached", 32'h0800_7040, 40'h0, 1'b1, 1'b1, 2);
  endtask

  task automatic t_range();
    expect_xlat("R8 index at depth", 32'h0840_0000, 40'h0, 1'b1, 1'b1, 1);
    expect_xlat("R8 window last byte", 32'h09FF_FFFF, 40'h0, 1'b1, 1'b1, 1);
  endtask

  task automatic t_enable();
    cfg_ctl = 4'b0000;
    expect_xlat("R5 disabled", 32'h0800_0ABC, 40'h00_0800_0ABC, 1'b0, 1'b0, 1);
    cfg_ctl = 4'b0001;
    expect_xlat("R5 re-enabled", 32'h0800_0ABC, 40'h9A_1234_5ABC, 1'b0, 1'b1, 1);
  endtask

  task automatic t_limit();
    do_flush();
    cfg_ctl = 4'b0101; // order 2: 128 MB window from 0x0800_0000
    expect_xlat("R3 order widens window", 32'h0F00_0000, 40'h0, 1'b1, 1'b1, 1);
    cfg_base = 15'h7F; cfg_ctl = 4'b0001;
    tbl_write(1, mk_ent(40'h33_4444_1000, 1'b1));
    expect_xlat("R4 end at 4GB enabled", 32'hFE00_1234, 40'h33_4444_1234, 1'b0, 1'b1, 2);
    cfg_ctl = 4'b0011;
    expect_xlat("R4 end past 4GB disabled", 32'hFE00_1234, 40'h00_FE00_1234, 1'b0, 1'b0, 1);
    cfg_base = 15'd4; cfg_ctl = 4'b0001;
    do_flush();
  endtask

  task automatic t_flush();
    expect_xlat("R10 fill old", 32'h0800_0ABC, 40'h9A_1234_5ABC, 1'b0, 1'b1, 2);
    tbl_write(0, mk_ent(40'h77_5555_6000, 1'b1));
    expect_xlat("R10 stale kept", 32'h0800_0ABC, 40'h9A_1234_5ABC, 1'b0, 1'b1, 1);
    do_flush();
    expect_xlat("R10 after flush", 32'h0800_0ABC, 40'h77_5555_6ABC, 1'b0, 1'b1, 2);
  endtask

  task automatic t_rr();
    for (int i = 10; i <= 14; i++)
      tbl_write(i, mk_ent(40'h10_0000_0000 | (40'(i) << 12), 1'b1));
    do_flush();
    for (int i = 10; i <= 13; i++)
      expect_xlat("R11 fill", 32'h0800_0000 + (i << 12), 40'h10_0000_0000 | (40'(i) << 12), 1'b0, 1'b1, 2);
    expect_xlat("R11 resident", 32'h0800_A000, 40'h10_0000_A000, 1'b0, 1'b1, 1);
    expect_xlat("R11 fifth page", 32'h0800_E000, 40'h10_0000_E000, 1'b0, 1'b1, 2);
    expect_xlat("R11 oldest evicted", 32'h0800_A000, 40'h10_0000_A000, 1'b0, 1'b1, 2);
    expect_xlat("R11 untouched slot", 32'h0800_C000, 40'h10_0000_C000, 1'b0, 1'b1, 1);
  endtask

  task automatic t_hold();
    logic [39:0] first;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0800_C010;
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_addr;
    check("R12 response up", 64'(rsp_valid), 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 valid held", 64'(rsp_valid), 64'd1);
      check("R12 addr held", 64'(rsp_addr), 64'(first));
      check("R12 ready low", 64'(req_ready), 64'd0);
    end
    check("R12 value", 64'(first), 64'h10_0000_C010);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R12 released", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_pass();
    t_translate();
    t_invalid();
    t_range();
    t_enable();
    t_limit();
    t_flush();
    t_rr();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule